// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block holds the handshake and flag state of one device-side USB control endpoint. An upstream packet engine hands it decoded events as single-cycle pulses: a SETUP packet arrived, an OUT data packet arrived, an IN token arrived, and the host acknowledged a transmitted IN packet. For every SETUP, OUT or IN event the block returns one handshake decision (ACK, NAK, or send the committed IN data). It also keeps four flags that firmware can see: SETUP received, OUT data received, bank ready for IN data, and IN token answered with NAK. One data bank is shared between the directions.

Firmware uses a write port of strobe bits to clear flags. Clearing the IN-ready flag commits the IN packet currently in the bank, with the byte count given on a side input. The response channel has no back-pressure. A decision appears as a one-cycle `resp_valid_o` pulse, and the packet engine must take it in that cycle. The event inputs accept one token per cycle: when several token pulses coincide, SETUP is taken first, then OUT, then IN. The others are dropped. When the host asks for data and the endpoint has none, an IN token is answered with NAK and the NAKed-IN flag is raised. During a control write this tells firmware that the status stage has begun.

Status bit layout (`stat_o`): bit 0 SETUP received, bit 1 OUT received, bit 2 IN ready, bit 3 NAKed IN, bit 4 FIFO-control (always 0). The write strobes in `reg_wdata_i` use the same bit numbers. Writing a 1 to a bit clears the matching flag. Bit 4 is accepted and ignored. Response codes on `resp_code_o` are 0 = ACK, 1 = NAK, 2 = DATA.

Top module: `ctrl_ep_hs`

## Requirements
- R1: A SETUP event is always answered with ACK (code 0), whatever the flags and the bank hold.
- R2: A SETUP event sets status bit 0 and leaves status bit 1 unchanged.
- R3: An OUT event is answered with ACK and sets status bit 1 when status bits 0 and 1 are both clear.
- R4: An OUT event that arrives while status bit 0 or bit 1 is set is answered with NAK (code 1) and changes no flag.
- R5: An IN event with no committed IN data is answered with NAK and sets status bit 3. With committed data it is answered with DATA (code 2).
- R6: A write with bit 2 set, while status bit 2 is set and `in_bytes_i` is below MAX_PKT, clears bit 2 and commits that byte count, which `tx_len_o` then shows. A byte count of MAX_PKT or more makes the commit ignored, and bit 2 stays set.
- R7: A transmit-done event while data is committed releases the bank: status bit 2 is set again, and the next IN event is answered with NAK.
- R8: When firmware clears a set SETUP or OUT flag and no IN data is committed, status bit 2 is set.
- R9: If a flag's set event and its clear strobe fall in the same cycle, the flag ends up set.
- R10: Status bit 4 always reads 0, and writing bit 4 changes no flag.
- R11: A SETUP event cancels committed IN data and clears status bit 2, so a following IN event is answered with NAK.
- R12: Coincident SETUP, OUT and IN events produce one response, for the highest-priority event (SETUP, then OUT, then IN).
- R13: Responses and flag updates appear on the first rising clock edge after the event and not before it.
- R14: After reset all status bits are 0 and `resp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_rx_i | input | 1 | SETUP packet received pulse |
| out_rx_i | input | 1 | OUT data packet received pulse |
| in_tok_i | input | 1 | IN token received pulse |
| tx_done_i | input | 1 | Host acknowledged the transmitted IN packet |
| reg_we_i | input | 1 | Firmware write strobe |
| reg_wdata_i | input | 5 | Firmware write data (clear strobes, bit 4 ignored) |
| in_bytes_i | input | CNT_W | Byte count of the IN packet being committed |
| stat_o | output | 5 | Status flags |
| resp_valid_o | output | 1 | Handshake decision valid (one cycle) |
| resp_code_o | output | 2 | Handshake decision: 0 ACK, 1 NAK, 2 DATA |
| tx_len_o | output | CNT_W | Byte count of the committed IN packet |

## Verification
Every result of this block is registered once. A response, a flag change or a new `tx_len_o` therefore appears on the first rising edge after the stimulus and stays until the next edge. The bench applies each stimulus at a falling edge and samples at the next falling edge, which is exactly one edge later. It also has one check that looks just after the stimulus is applied, before any edge, and finds no response yet. Stimuli last one cycle and are removed at the sampling edge, so no event is counted twice.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;
  localparam int REG_W = 5;

  localparam int ST_SETUP = 0;
  localparam int ST_OUT   = 1;
  localparam int ST_INRDY = 2;
  localparam int ST_NAKIN = 3;
  localparam int ST_FIFO  = 4;
  localparam int NFLAGS   = 4;

  typedef enum logic [1:0] {
    HS_ACK  = 2'd0,
    HS_NAK  = 2'd1,
    HS_DATA = 2'd2
  } hs_code_e;
endpackage

// File: rtl/ep_flag_cell.sv
module ep_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/ep_token_arb.sv
module ep_token_arb (
  input  logic setup_rx_i,
  input  logic out_rx_i,
  input  logic in_tok_i,
  input  logic f_setup_i,
  input  logic f_out_i,
  input  logic pend_i,
  output logic tok_setup_o,
  output logic out_ack_o,
  output logic out_nak_o,
  output logic in_data_o,
  output logic in_nak_o
);
  logic tok_out, tok_in, bank_busy;

  always_comb begin
    tok_setup_o = setup_rx_i;
    tok_out     = out_rx_i & ~setup_rx_i;
    tok_in      = in_tok_i & ~setup_rx_i & ~out_rx_i;
    bank_busy   = f_setup_i | f_out_i;
    out_ack_o   = tok_out & ~bank_busy;
    out_nak_o   = tok_out & bank_busy;
    in_data_o   = tok_in & pend_i;
    in_nak_o    = tok_in & ~pend_i;
  end
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl #(
  parameter int MAX_PKT = 64,
  parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_setup_i,
  input  logic             tx_done_i,
  input  logic             commit_req_i,
  input  logic             release_i,
  input  logic             f_inrdy_i,
  input  logic [CNT_W-1:0] in_bytes_i,
  output logic             pend_o,
  output logic [CNT_W-1:0] tx_len_o,
  output logic             inrdy_set_o,
  output logic             inrdy_clr_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PKT);

  logic commit, tx_sent, size_ok;

  always_comb begin
    size_ok     = in_bytes_i < MAX_C;
    commit      = commit_req_i & f_inrdy_i & size_ok & ~tok_setup_i;
    tx_sent     = tx_done_i & pend_o & ~tok_setup_i;
    inrdy_set_o = (release_i & ~pend_o & ~commit) | tx_sent;
    inrdy_clr_o = commit | tok_setup_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o   <= 1'b0;
      tx_len_o <= '0;
    end else begin
      if (tok_setup_i)  pend_o <= 1'b0;
      else if (commit)  pend_o <= 1'b1;
      else if (tx_sent) pend_o <= 1'b0;
      if (commit) tx_len_o <= in_bytes_i;
    end
  end
endmodule

// File: rtl/ep_resp_gen.sv
module ep_resp_gen
  import ctrl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_setup_i,
  input  logic       out_ack_i,
  input  logic       out_nak_i,
  input  logic       in_data_i,
  input  logic       in_nak_i,
  output logic       resp_valid_o,
  output logic [1:0] resp_code_o
);
  hs_code_e code_d;
  logic     any_tok;

  always_comb begin
    any_tok = tok_setup_i | out_ack_i | out_nak_i | in_data_i | in_nak_i;
    if (tok_setup_i || out_ack_i) code_d = HS_ACK;
    else if (in_data_i)           code_d = HS_DATA;
    else                          code_d = HS_NAK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_code_o  <= HS_ACK;
    end else begin
      resp_valid_o <= any_tok;
      if (any_tok) resp_code_o <= code_d;
    end
  end
endmodule

// File: rtl/ctrl_ep_hs.sv
module ctrl_ep_hs
  import ctrl_ep_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_rx_i,
  input  logic             out_rx_i,
  input  logic             in_tok_i,
  input  logic             tx_done_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic [CNT_W-1:0] in_bytes_i,
  output logic [REG_W-1:0] stat_o,
  output logic             resp_valid_o,
  output logic [1:0]       resp_code_o,
  output logic [CNT_W-1:0] tx_len_o
);
  logic tok_setup, out_ack, out_nak, in_data, in_nak;
  logic pend_q, inrdy_set, inrdy_clr, bank_release;
  logic [NFLAGS-1:0] flag_q, flag_set, flag_clr, fw_clr;

  ep_token_arb u_arb (
    .setup_rx_i (setup_rx_i),
    .out_rx_i   (out_rx_i),
    .in_tok_i   (in_tok_i),
    .f_setup_i  (flag_q[ST_SETUP]),
    .f_out_i    (flag_q[ST_OUT]),
    .pend_i     (pend_q),
    .tok_setup_o(tok_setup),
    .out_ack_o  (out_ack),
    .out_nak_o  (out_nak),
    .in_data_o  (in_data),
    .in_nak_o   (in_nak)
  );

  always_comb begin
    fw_clr = reg_we_i ? reg_wdata_i[NFLAGS-1:0] : '0;
    bank_release = ~tok_setup &
                   ((fw_clr[ST_SETUP] & flag_q[ST_SETUP]) |
                    (fw_clr[ST_OUT]   & flag_q[ST_OUT]));
    flag_set = '0;
    flag_clr = fw_clr;
    flag_set[ST_SETUP] = tok_setup;
    flag_set[ST_OUT]   = out_ack;
    flag_set[ST_INRDY] = inrdy_set;
    flag_clr[ST_INRDY] = inrdy_clr;
    flag_set[ST_NAKIN] = in_nak;
  end

  ep_bank_ctrl #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_setup_i (tok_setup),
    .tx_done_i   (tx_done_i),
    .commit_req_i(fw_clr[ST_INRDY]),
    .release_i   (bank_release),
    .f_inrdy_i   (flag_q[ST_INRDY]),
    .in_bytes_i  (in_bytes_i),
    .pend_o      (pend_q),
    .tx_len_o    (tx_len_o),
    .inrdy_set_o (inrdy_set),
    .inrdy_clr_o (inrdy_clr)
  );

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    ep_flag_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(flag_set[g]),
      .clr_i(flag_clr[g]),
      .q_o  (flag_q[g])
    );
  end

  ep_resp_gen u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_setup_i (tok_setup),
    .out_ack_i   (out_ack),
    .out_nak_i   (out_nak),
    .in_data_i   (in_data),
    .in_nak_i    (in_nak),
    .resp_valid_o(resp_valid_o),
    .resp_code_o (resp_code_o)
  );

  // FIFO-control bit is inert on a control endpoint: always reads zero
  always_comb begin
    stat_o = '0;
    stat_o[NFLAGS-1:0] = flag_q;
    stat_o[ST_FIFO] = 1'b0;
  end
endmodule

// File: rtl/ctrl_ep_hs_chk.sv
module ctrl_ep_hs_chk
  import ctrl_ep_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             setup_rx_i,
  input logic             out_rx_i,
  input logic             in_tok_i,
  input logic             reg_we_i,
  input logic [REG_W-1:0] stat_o,
  input logic             resp_valid_o,
  input logic [1:0]       resp_code_o,
  input logic             pend_q
);
  assert_setup_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx_i |=> resp_valid_o && resp_code_o == HS_ACK);

  assert_setup_not_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx_i && !stat_o[ST_OUT] |=> stat_o[ST_SETUP] && !stat_o[ST_OUT]);

  assert_out_nak_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_rx_i && !setup_rx_i && !reg_we_i && (stat_o[ST_SETUP] || stat_o[ST_OUT])
    |=> resp_code_o == HS_NAK && $stable(stat_o[ST_OUT:ST_SETUP]));

  assert_in_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok_i && !setup_rx_i && !out_rx_i && !pend_q
    |=> resp_valid_o && resp_code_o == HS_NAK && stat_o[ST_NAKIN]);

  assert_setup_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx_i |=> !stat_o[ST_INRDY] && !pend_q);

  assert_code_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> resp_code_o != 2'd3);
endmodule

bind ctrl_ep_hs ctrl_ep_hs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_rx_i  (setup_rx_i),
  .out_rx_i    (out_rx_i),
  .in_tok_i    (in_tok_i),
  .reg_we_i    (reg_we_i),
  .stat_o      (stat_o),
  .resp_valid_o(resp_valid_o),
  .resp_code_o (resp_code_o),
  .pend_q      (pend_q)
);

// File: tb/ctrl_ep_hs_tb_top.sv
module ctrl_ep_hs_tb_top;
  localparam int MAX_PKT = 64;
  localparam int CNT_W   = $clog2(MAX_PKT + 1);
  localparam int NV      = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_rx = 1'b0, out_rx = 1'b0, in_tok = 1'b0, tx_done = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [CNT_W-1:0] in_bytes = '0;
  logic [4:0] stat;
  logic resp_valid;
  logic [1:0] resp_code;
  logic [CNT_W-1:0] tx_len;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ctrl_ep_hs #(.MAX_PKT(MAX_PKT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .setup_rx_i(setup_rx), .out_rx_i(out_rx), .in_tok_i(in_tok), .tx_done_i(tx_done),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .in_bytes_i(in_bytes),
    .stat_o(stat), .resp_valid_o(resp_valid), .resp_code_o(resp_code), .tx_len_o(tx_len)
  );

  // vector: {ev[3:0]=setup,out,in,txdone, we, wdata[7:0], bytes[6:0], rv, code[1:0], stat[7:0]}
  function automatic logic [30:0] mk(logic [3:0] ev, logic we, logic [7:0] wd,
                                     logic [6:0] by, logic rv, logic [1:0] cd, logic [7:0] st);
    return {ev, we, wd, by, rv, cd, st};
  endfunction

  localparam logic [30:0] VEC [NV] = '{
    mk(4'b1000, 0, 8'h00,  0, 1, 2'd0, 8'h01),
    mk(4'b0100, 0, 8'h00,  0, 1, 2'd1, 8'h01),
    mk(4'b0010, 0, 8'h00,  0, 1, 2'd1, 8'h09),
    mk(4'b0000, 1, 8'h09,  0, 0, 2'd0, 8'h04),
    mk(4'b0000, 1, 8'h04, 64, 0, 2'd0, 8'h04),
    mk(4'b0000, 1, 8'h04, 18, 0, 2'd0, 8'h00),
    mk(4'b0010, 0, 8'h00,  0, 1, 2'd2, 8'h00),
    mk(4'b0001, 0, 8'h00,  0, 0, 2'd0, 8'h04),
    mk(4'b0010, 0, 8'h00,  0, 1, 2'd1, 8'h0C),
    mk(4'b0000, 1, 8'h10,  0, 0, 2'd0, 8'h0C),
    mk(4'b0000, 1, 8'h08,  0, 0, 2'd0, 8'h04),
    mk(4'b0100, 0, 8'h00,  0, 1, 2'd0, 8'h06),
    mk(4'b0100, 0, 8'h00,  0, 1, 2'd1, 8'h06),
    mk(4'b0000, 1, 8'h02,  0, 0, 2'd0, 8'h04),
    mk(4'b0000, 1, 8'h04,  0, 0, 2'd0, 8'h00),
    mk(4'b1000, 0, 8'h00,  0, 1, 2'd0, 8'h01),
    mk(4'b0010, 0, 8'h00,  0, 1, 2'd1, 8'h09),
    mk(4'b1000, 1, 8'h01,  0, 1, 2'd0, 8'h09),
    mk(4'b1110, 0, 8'h00,  0, 1, 2'd0, 8'h09),
    mk(4'b0000, 1, 8'h09,  0, 0, 2'd0, 8'h04)
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2"; 1: return "R4"; 2: return "R5"; 3: return "R8";
      4: return "R6"; 5: return "R6"; 6: return "R5"; 7: return "R7";
      8: return "R7"; 9: return "R10"; 10: return "R5"; 11: return "R3";
      12: return "R4"; 13: return "R8"; 14: return "R6"; 15: return "R1";
      16: return "R11"; 17: return "R9"; 18: return "R12"; default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [3:0] ev, logic we, logic [4:0] wd, logic [CNT_W-1:0] by);
    {setup_rx, out_rx, in_tok, tx_done} = ev;
    reg_we = we; reg_wdata = wd; in_bytes = by;
    @(negedge clk);
    {setup_rx, out_rx, in_tok, tx_done} = '0;
    reg_we = 1'b0; reg_wdata = '0; in_bytes = '0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state
    check(stat == 5'h00, "R14 stat", stat, 0);
    check(resp_valid == 1'b0, "R14 resp", resp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30:27], VEC[i][26], VEC[i][22:18], VEC[i][17:11]);
      check(resp_valid == VEC[i][10], vtag(i), resp_valid, VEC[i][10]);
      if (VEC[i][10])
        check(resp_code == VEC[i][9:8], vtag(i), resp_code, VEC[i][9:8]);
      check(stat == VEC[i][4:0], vtag(i), stat, VEC[i][4:0]);
    end

    // R6 boundary: MAX_PKT-1 accepted, length shown with DATA
    step(4'b0000, 1'b1, 5'h04, CNT_W'(MAX_PKT - 1));
    check(stat == 5'h00, "R6 commit 63", stat, 0);
    step(4'b0010, 1'b0, 5'h00, '0);
    check(resp_code == 2'd2, "R6 data", resp_code, 2);
    check(tx_len == CNT_W'(MAX_PKT - 1), "R6 len", tx_len, MAX_PKT - 1);

    // R7 then R9 on the NAKed-IN flag
    step(4'b0001, 1'b0, 5'h00, '0);
    check(stat == 5'h04, "R7 release", stat, 4);
    step(4'b0010, 1'b0, 5'h00, '0);
    check(stat == 5'h0C, "R5 nakin", stat, 12);
    step(4'b0010, 1'b1, 5'h08, '0);
    check(stat == 5'h0C, "R9 nakin kept", stat, 12);
    check(resp_code == 2'd1, "R9 nak", resp_code, 1);

    // R13: nothing before the edge, result right after it
    @(negedge clk);
    setup_rx = 1'b1;
    #1;
    check(resp_valid == 1'b0 && stat[0] == 1'b0, "R13 early", {resp_valid, stat[0]}, 0);
    @(negedge clk);
    setup_rx = 1'b0;
    check(resp_valid == 1'b1 && stat[0] == 1'b1, "R13 due", {resp_valid, stat[0]}, 3);

    // R14: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(stat == 5'h00, "R14 rerun stat", stat, 0);
    check(resp_valid == 1'b0, "R14 rerun resp", resp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule